// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A fast oscillator tick enters a divider. Every `TICKS_PER_SEC` enabled ticks, the divider produces one one-second step. That step ripples through the time and date fields, with the right rollover at each boundary. Month length is taken into account, and February gets a 29th day when the year is a multiple of four.

The hours register carries its own format selector. In one setting it counts 00 to 23. In the other it counts 1 to 12 and carries a separate PM flag. A bus interface loads any field through a single-cycle write port and reads any field through a combinational read port. A write also restarts the divider, so a freshly loaded time is held for one whole second. A stop flag in the control register halts the tick, but only while the chip runs from backup power. The block does no range checking: loading an invalid time or date gives undefined results.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00, control 0x00.
- R2: When `wr_en` is high, the register at `wr_addr` loads `wr_data` masked to its implemented bits. Address map and masks: 0 seconds 0x7F, 1 minutes 0x7F, 2 hours 0x7F, 3 day of week 0x07, 4 date 0x3F, 5 month 0x1F, 6 year 0xFF, 7 control 0x80. Reading any other address returns 0x00, and writes to those addresses change nothing.
- R3: With no write in progress, the seconds field advances by one BCD count on exactly every `TICKS_PER_SEC`-th enabled tick, and at no other time.
- R4: A write clears the tick divider, so `TICKS_PER_SEC` further ticks are needed before the next step. When a write and the terminal tick fall in the same cycle, the written value is kept and no step occurs.
- R5: Seconds roll from 0x59 to 0x00 and advance the minutes. Minutes roll from 0x59 to 0x00 and advance the hour.
- R6: With hours bit 6 = 0 (24-hour format), the hour counts 0x00 to 0x23. The step from 0x23 goes to 0x00 and advances the day.
- R7: With hours bit 6 = 1 (12-hour format), bits 4:0 hold the hour 01 to 12 and bit 5 is PM. The hour steps from 11 to 12 and PM toggles. It steps from 12 to 01 with PM unchanged. Only the step from 11 PM to 12 AM advances the day. Bit 6 changes only by a write.
- R8: Day of week counts 1 (Sunday) to 7 and wraps from 7 to 1 on each day advance.
- R9: On a day advance, the date wraps to 0x01 after the last day of its month and advances the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year is divisible by 4 and 28 otherwise. All other months have 31 days.
- R10: Month rolls from 0x12 to 0x01 and advances the year. Year rolls from 0x99 to 0x00.
- R11: Control bit 7 is the stop flag. While it is 1 and `on_backup` is 1, ticks are ignored and neither the time nor the divider advances. With either of them 0, time runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse from the oscillator, `TICKS_PER_SEC` per second |
| on_backup | input | 1 | High while the chip is running from backup power |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |

## Verification
A bus write and the divider's terminal tick can land in the same clock cycle. Either one on its own would change the seconds register. The bench starts a fresh second with a write, then applies exactly `TICKS_PER_SEC - 1` ticks. In the next cycle it raises the write strobe and the tick together. It then checks that the written value stands and that the next step comes only after a full further count of ticks, which would not happen if the divider had slipped or the step had overridden the write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned REG_SEC  = 0;
    localparam int unsigned REG_MIN  = 1;
    localparam int unsigned REG_HOUR = 2;
    localparam int unsigned REG_DOW  = 3;
    localparam int unsigned REG_DATE = 4;
    localparam int unsigned REG_MON  = 5;
    localparam int unsigned REG_YEAR = 6;
    localparam int unsigned REG_CTRL = 7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hr;    // [6] 12h select, [5] PM or tens, [4:0] hour
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
        logic       stop;  // control bit 7
    } cal_t;

    // Packed BCD increment with no wrap; caller handles rollover
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic clear,
    output logic sec_pulse
);
    localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        sec_pulse = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (tick_in) begin
            if (cnt_q == LAST) begin
                cnt_d     = '0;
                sec_pulse = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
    input  logic [6:0] hr_in,
    output logic [6:0] hr_out,
    output logic       day_carry
);
    import rtc_pkg::*;

    logic       pm;
    logic [4:0] h12;
    logic [5:0] h24;

    always_comb begin
        pm        = hr_in[5];
        h12       = hr_in[4:0];
        h24       = hr_in[5:0];
        hr_out    = hr_in;
        day_carry = 1'b0;
        if (hr_in[6]) begin
            if (h12 == 5'h11) begin
                hr_out    = {1'b1, ~pm, 5'h12};
                day_carry = pm;
            end else if (h12 == 5'h12) begin
                hr_out = {1'b1, pm, 5'h01};
            end else begin
                hr_out = {1'b1, pm, 5'(bcd_inc({3'b000, h12}))};
            end
        end else begin
            if (h24 == 6'h23) begin
                hr_out    = 7'h00;
                day_carry = 1'b1;
            end else begin
                hr_out = {1'b0, 6'(bcd_inc({2'b00, h24}))};
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [4:0] mon,
    input  logic [7:0] yr,
    output logic [5:0] last_date
);
    logic [7:0] yr_bin;
    logic       leap;

    always_comb begin
        yr_bin = ({4'b0, yr[7:4]} << 3) + ({4'b0, yr[7:4]} << 1) + {4'b0, yr[3:0]};
        leap   = (yr_bin % 8'd4) == 8'd0;
        case (mon)
            5'h02:                      last_date = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned ADDR_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              on_backup,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    import rtc_pkg::*;

    localparam cal_t CAL_RESET = '{sec: 7'h00, min: 7'h00, hr: 7'h00, dow: 3'd1,
                                   date: 6'h01, mon: 5'h01, yr: 8'h00, stop: 1'b0};

    cal_t       cal_d, cal_q;
    logic       tick_en;
    logic       sec_pulse;
    logic [6:0] hr_next;
    logic       hr_carry;
    logic [5:0] last_date;

    assign tick_en = osc_tick && !(cal_q.stop && on_backup);

    rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_en),
        .clear     (wr_en),
        .sec_pulse (sec_pulse)
    );

    rtc_hour_step u_hour (
        .hr_in     (cal_q.hr),
        .hr_out    (hr_next),
        .day_carry (hr_carry)
    );

    rtc_month_len u_mlen (
        .mon       (cal_q.mon),
        .yr        (cal_q.yr),
        .last_date (last_date)
    );

    always_comb begin
        cal_d = cal_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(REG_SEC):  cal_d.sec  = wr_data[6:0];
                ADDR_W'(REG_MIN):  cal_d.min  = wr_data[6:0];
                ADDR_W'(REG_HOUR): cal_d.hr   = wr_data[6:0];
                ADDR_W'(REG_DOW):  cal_d.dow  = wr_data[2:0];
                ADDR_W'(REG_DATE): cal_d.date = wr_data[5:0];
                ADDR_W'(REG_MON):  cal_d.mon  = wr_data[4:0];
                ADDR_W'(REG_YEAR): cal_d.yr   = wr_data;
                ADDR_W'(REG_CTRL): cal_d.stop = wr_data[7];
                default: ;
            endcase
        end else if (sec_pulse) begin
            if (cal_q.sec != 7'h59) begin
                cal_d.sec = 7'(bcd_inc({1'b0, cal_q.sec}));
            end else begin
                cal_d.sec = 7'h00;
                if (cal_q.min != 7'h59) begin
                    cal_d.min = 7'(bcd_inc({1'b0, cal_q.min}));
                end else begin
                    cal_d.min = 7'h00;
                    cal_d.hr  = hr_next;
                    if (hr_carry) begin
                        cal_d.dow = (cal_q.dow == 3'd7) ? 3'd1 : cal_q.dow + 3'd1;
                        if (cal_q.date != last_date) begin
                            cal_d.date = 6'(bcd_inc({2'b00, cal_q.date}));
                        end else begin
                            cal_d.date = 6'h01;
                            if (cal_q.mon != 5'h12) begin
                                cal_d.mon = 5'(bcd_inc({3'b000, cal_q.mon}));
                            end else begin
                                cal_d.mon = 5'h01;
                                cal_d.yr  = (cal_q.yr == 8'h99) ? 8'h00 : bcd_inc(cal_q.yr);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end

    always_comb begin
        case (rd_addr)
            ADDR_W'(REG_SEC):  rd_data = {1'b0, cal_q.sec};
            ADDR_W'(REG_MIN):  rd_data = {1'b0, cal_q.min};
            ADDR_W'(REG_HOUR): rd_data = {1'b0, cal_q.hr};
            ADDR_W'(REG_DOW):  rd_data = {5'b0, cal_q.dow};
            ADDR_W'(REG_DATE): rd_data = {2'b0, cal_q.date};
            ADDR_W'(REG_MON):  rd_data = {3'b0, cal_q.mon};
            ADDR_W'(REG_YEAR): rd_data = cal_q.yr;
            ADDR_W'(REG_CTRL): rd_data = {cal_q.stop, 7'b0};
            default:           rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_checks.sv
module rtc_checks #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              on_backup,
    input logic              sec_pulse,
    input logic [6:0]        sec_q,
    input logic [6:0]        hr_q,
    input logic              stop_q
);
    // R2: a seconds write lands in the register on the next edge
    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> sec_q == $past(wr_data[6:0]));

    // R3: seconds hold unless a step or a write occurs
    p_hold_between_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sec_pulse) |=> $stable(sec_q));

    // R4: a write suppresses the step in its cycle
    p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sec_pulse);

    // R5: seconds wrap to zero from 59
    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !wr_en && sec_q == 7'h59) |=> sec_q == 7'h00);

    // R7: format bit moves only by a write
    p_mode_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hr_q[6]));

    // R11: stopped on backup power means no steps
    p_stop_on_backup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && on_backup) |-> !sec_pulse);
endmodule

bind rtc_bcd_calendar rtc_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .on_backup (on_backup),
    .sec_pulse (sec_pulse),
    .sec_q     (cal_q.sec),
    .hr_q      (cal_q.hr),
    .stop_q    (cal_q.stop)
);

// File: tb/test_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module test_rtc_bcd_calendar;
    localparam int unsigned TPS = 4;
    localparam int unsigned AW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick = 1'b0;
    logic          on_backup = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    rtc_bcd_calendar #(.TICKS_PER_SEC(TPS), .ADDR_W(AW)) i_rtc_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .on_backup(on_backup),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input int a, input logic [7:0] exp, input string req);
        rd_addr = AW'(a);
        #0.5;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    // load a date with the clock at hh:59:59 in the given hour code
    task automatic preset(input logic [7:0] hr, input logic [7:0] dow,
                          input logic [7:0] date, input logic [7:0] mon, input logic [7:0] yr);
        wr(1, 8'h59); wr(2, hr); wr(3, dow); wr(4, date); wr(5, mon); wr(6, yr); wr(0, 8'h59);
    endtask

    task automatic t_reset();
        chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h01, "R1");
        chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h00, "R1"); chk(7, 8'h00, "R1");
    endtask

    task automatic t_write_map();
        wr(0, 8'hFF); chk(0, 8'h7F, "R2");
        wr(2, 8'hFF); chk(2, 8'h7F, "R2");
        wr(3, 8'hFF); chk(3, 8'h07, "R2");
        wr(4, 8'hFF); chk(4, 8'h3F, "R2");
        wr(5, 8'hFF); chk(5, 8'h1F, "R2");
        wr(6, 8'hA5); chk(6, 8'hA5, "R2");
        wr(7, 8'h7F); chk(7, 8'h00, "R2");
        wr(9, 8'h33); chk(9, 8'h00, "R2");
        chk(6, 8'hA5, "R2");
    endtask

    task automatic t_divider();
        wr(2, 8'h05); wr(1, 8'h10); wr(0, 8'h00);
        tick(TPS - 1); chk(0, 8'h00, "R3");
        tick(1);       chk(0, 8'h01, "R3");
        tick(TPS);     chk(0, 8'h02, "R3");
        tick(TPS * 8); chk(0, 8'h10, "R3");
    endtask

    task automatic t_collision();
        wr(0, 8'h20);
        tick(2); wr(0, 8'h25);
        tick(TPS - 1); chk(0, 8'h25, "R4");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = '0; wr_data = 8'h30; osc_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; osc_tick = 1'b0;
        chk(0, 8'h30, "R4");
        tick(TPS - 1); chk(0, 8'h30, "R4");
        tick(1);       chk(0, 8'h31, "R4");
    endtask

    task automatic t_sec_min();
        preset(8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
        tick(TPS);
        chk(0, 8'h00, "R5"); chk(1, 8'h00, "R5"); chk(2, 8'h06, "R5"); chk(4, 8'h10, "R5");
    endtask

    task automatic t_24h();
        preset(8'h23, 8'h03, 8'h15, 8'h06, 8'h21);
        tick(TPS);
        chk(2, 8'h00, "R6"); chk(3, 8'h04, "R6"); chk(4, 8'h16, "R6");
        preset(8'h09, 8'h03, 8'h15, 8'h06, 8'h21);
        tick(TPS); chk(2, 8'h10, "R6");
    endtask

    task automatic t_12h();
        preset(8'h51, 8'h02, 8'h10, 8'h03, 8'h21);   // 11 AM
        tick(TPS); chk(2, 8'h72, "R7"); chk(4, 8'h10, "R7");
        wr(1, 8'h59); wr(0, 8'h59);
        tick(TPS); chk(2, 8'h61, "R7");
        preset(8'h71, 8'h02, 8'h10, 8'h03, 8'h21);   // 11 PM
        tick(TPS); chk(2, 8'h52, "R7"); chk(3, 8'h03, "R7"); chk(4, 8'h11, "R7");
        wr(1, 8'h59); wr(0, 8'h59);
        tick(TPS); chk(2, 8'h41, "R7");
    endtask

    task automatic t_dow();
        preset(8'h23, 8'h07, 8'h10, 8'h03, 8'h21);
        tick(TPS); chk(3, 8'h01, "R8");
    endtask

    task automatic t_month_len();
        preset(8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        tick(TPS); chk(4, 8'h29, "R9"); chk(5, 8'h02, "R9");
        preset(8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
        tick(TPS); chk(4, 8'h01, "R9"); chk(5, 8'h03, "R9");
        preset(8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        tick(TPS); chk(4, 8'h01, "R9"); chk(5, 8'h03, "R9");
        preset(8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
        tick(TPS); chk(4, 8'h01, "R9"); chk(5, 8'h05, "R9");
        preset(8'h23, 8'h01, 8'h30, 8'h05, 8'h23);
        tick(TPS); chk(4, 8'h31, "R9");
    endtask

    task automatic t_year();
        preset(8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
        tick(TPS);
        chk(4, 8'h01, "R10"); chk(5, 8'h01, "R10"); chk(6, 8'h00, "R10");
        preset(8'h23, 8'h01, 8'h31, 8'h12, 8'h19);
        tick(TPS); chk(6, 8'h20, "R10");
    endtask

    task automatic t_stop();
        wr(0, 8'h40); wr(7, 8'h80); chk(7, 8'h80, "R11");
        on_backup = 1'b1;
        tick(TPS * 2); chk(0, 8'h40, "R11");
        on_backup = 1'b0;
        tick(TPS); chk(0, 8'h41, "R11");
        wr(7, 8'h00); wr(0, 8'h40);
        on_backup = 1'b1;
        tick(TPS); chk(0, 8'h41, "R11");
        on_backup = 1'b0;
    endtask

    initial begin
        #50000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #9; rst_n = 1'b1;
        t_reset();
        t_write_map();
        t_divider();
        t_collision();
        t_sec_min();
        t_24h();
        t_12h();
        t_dow();
        t_month_len();
        t_year();
        t_stop();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule